// File: doc/BRIEF.md
# Ring-Walking Demand DMA Engine

This block is a single-channel DMA engine that empties a FIFO into host memory. Software builds a circular chain of four-word descriptors in host memory, writes the address of the first one into a pointer register, and starts the engine with one write to a command/status byte. The engine then reads each descriptor and moves the programmed number of 32-bit words from the FIFO to consecutive host addresses. It moves on to the next descriptor through the link word. Because the last link points back to the first descriptor, the engine keeps running until it is stopped.

The FIFO side is one fixed location. The engine exposes the descriptor's local address unchanged for the whole transfer and issues a data beat only while the FIFO asserts demand. The live host address can be read at all times, so software can see how far the ring has been filled. A descriptor whose link carries the terminal-count flag raises an interrupt when its last word has been written. A clear bit in the command byte drops that interrupt. Aborting lets a beat already on the memory port finish, then parks the engine with a done flag.

Descriptor layout, by word offset from a 16-byte aligned base: 0 host start address, 1 local (FIFO) address, 2 byte count, 3 link. Link bits: 0 descriptor is in host memory, 1 interrupt at terminal count, 2 direction is local-to-host; bits 31:4 give the next base. Command/status byte: bit 0 enable, bit 1 start, bit 3 clear interrupt (write); bit 0 enable, bit 4 done, bit 5 interrupt pending (read).

Top module: `ring_dma_engine`

## Requirements
- R1: After synchronous reset the status byte reads 0, `irq` is low, no memory request is made and `host_addr` is 0.
- R2: A status write with bit 0 and bit 1 both set, while enable is clear, sets enable, clears done and reads descriptor words at base, base+4, base+8 and base+12, where base is the pointer register with bits 3:0 forced to zero.
- R3: A new data write request starts only in a cycle where `demand` is high, and `fifo_pop` is high exactly in cycles where a write request is accepted (`mem_req` and `mem_ready` both high).
- R4: The k-th accepted write of a descriptor goes to host start + 4k and carries the FIFO word, and `fifo_addr` equals descriptor word 1 for the whole transfer.
- R5: `host_addr` always equals the address the next data write will use, and it advances by 4 on every accepted write.
- R6: After byte count / 4 words (bits 1:0 of the count dropped), the engine fetches the descriptor at the link with bits 3:0 zeroed, so a link back to the first descriptor repeats the ring without end.
- R7: When the last word of a descriptor whose link bit 1 is set is accepted, the interrupt becomes pending (`irq` high, status bit 5); a descriptor with link bit 1 clear raises nothing.
- R8: A status write with bit 3 set and bit 0 set clears the pending interrupt and leaves enable unchanged.
- R9: A descriptor whose word count is zero produces no data write and no interrupt, and the engine goes straight on to its link.
- R10: Abort (the `abort` pin, or a status write with bit 0 clear while enabled) lets a held request complete. The engine then clears enable, sets done and makes no further requests.
- R11: A request that is not accepted stays asserted with the same address and direction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_we | input | 1 | Write strobe for the descriptor pointer register |
| ptr_wdata | input | 32 | Address of the first descriptor, flags in bits 3:0 |
| cs_we | input | 1 | Write strobe for the command/status byte |
| cs_wdata | input | 8 | Command byte: enable, start, clear interrupt |
| cs_rdata | output | 8 | Status byte: enable, done, interrupt pending |
| abort | input | 1 | Stop request |
| demand | input | 1 | FIFO has a word available |
| fifo_data | input | 32 | Word at the head of the FIFO |
| fifo_pop | output | 1 | FIFO word consumed this cycle |
| fifo_addr | output | 32 | Fixed local address of the current descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = data write, 0 = descriptor read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| host_addr | output | 32 | Next host address to be written |
| irq | output | 1 | Terminal-count interrupt pending |

## Verification
Some rules must hold on every cycle, and the assertions cover those. Requests held while the memory stalls, data beats that only start under demand, a FIFO address that stays fixed during a transfer, host-address steps of 4, a pending interrupt after a flagged terminal count, clear-interrupt leaving enable alone, and the quiet, done state after a halt are all checked that way. The bench's scenarios cover what needs a whole sequence. They check the exact address and data stream across a ring with a skipped empty descriptor and a truncated byte count, and the order of the descriptor fetches after start and after a restart. They also check the interrupt appearing once per ring pass, and abort releasing the engine only after a stalled beat is finally accepted.

// File: rtl/ring_dma_pkg.sv
`timescale 1ns/1ps
package ring_dma_pkg;
    localparam int WORD_W     = 32;
    localparam int BYTE_SH    = 2;                    // log2 of bytes per word
    localparam int CNT_W      = WORD_W - BYTE_SH;     // word counter width
    localparam int DESC_WORDS = 4;
    localparam int DIDX_W     = $clog2(DESC_WORDS);
    localparam int ALIGN_SH   = BYTE_SH + DIDX_W;     // descriptor alignment
    localparam int CS_W       = 8;

    // command / status byte
    localparam int CS_EN   = 0;
    localparam int CS_GO   = 1;
    localparam int CS_ACK  = 3;
    localparam int CS_DONE = 4;
    localparam int CS_PEND = 5;

    // link word flags
    localparam int LNK_HOST   = 0;
    localparam int LNK_TCIRQ  = 1;
    localparam int LNK_TOHOST = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {WK_IDLE, WK_FETCH, WK_MOVE} walk_t;

    typedef enum logic [DIDX_W-1:0] {
        DW_HOST  = 2'd0,
        DW_LOCAL = 2'd1,
        DW_SIZE  = 2'd2,
        DW_LINK  = 2'd3
    } dword_t;

    typedef struct packed {
        word_t fifo_addr;
        word_t link;
    } shadow_t;

    function automatic word_t desc_base(word_t p);
        return p & ~word_t'((1 << ALIGN_SH) - 1);
    endfunction

    function automatic word_t beat_step(word_t a);
        return a + word_t'(1 << BYTE_SH);
    endfunction
endpackage

// File: rtl/rdma_csr.sv
`timescale 1ns/1ps
module rdma_csr
    import ring_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ptr_we,
    input  word_t           ptr_wdata,
    input  logic            cs_we,
    input  logic [CS_W-1:0] cs_wdata,
    input  logic            abort,
    input  logic            tc_irq_i,
    input  logic            halt_i,
    output word_t           ptr_o,
    output logic            start_o,
    output logic            stop_req_o,
    output logic [CS_W-1:0] cs_rdata,
    output logic            irq_o
);
    logic  en_q, done_q, pend_q;
    word_t ptr_q;
    logic  unused_cs_bits;

    assign unused_cs_bits = ^{cs_wdata[CS_W-1:CS_DONE], cs_wdata[CS_ACK-1]};

    always_comb begin
        start_o    = cs_we && cs_wdata[CS_EN] && cs_wdata[CS_GO] && !en_q;
        stop_req_o = abort || (cs_we && !cs_wdata[CS_EN] && en_q);
        cs_rdata          = '0;
        cs_rdata[CS_EN]   = en_q;
        cs_rdata[CS_DONE] = done_q;
        cs_rdata[CS_PEND] = pend_q;
    end

    assign ptr_o = ptr_q;
    assign irq_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            done_q <= 1'b0;
            pend_q <= 1'b0;
            ptr_q  <= '0;
        end else begin
            if (ptr_we)
                ptr_q <= ptr_wdata;
            if (start_o) begin
                en_q   <= 1'b1;
                done_q <= 1'b0;
            end else if (halt_i) begin
                en_q   <= 1'b0;
                done_q <= 1'b1;
            end
            if (tc_irq_i)
                pend_q <= 1'b1;
            else if (cs_we && cs_wdata[CS_ACK])
                pend_q <= 1'b0;
        end
    end

    AST_ACK_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        (cs_we && cs_wdata[CS_ACK] && cs_wdata[CS_EN] && !cs_wdata[CS_GO] && !tc_irq_i && !halt_i)
        |=> (!irq_o && cs_rdata[CS_EN] == $past(cs_rdata[CS_EN]))); // R8

    AST_HALT_PARKS: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> (!cs_rdata[CS_EN] && cs_rdata[CS_DONE])); // R10

    AST_TC_PENDS: assert property (@(posedge clk) disable iff (rst)
        tc_irq_i |=> irq_o); // R7
endmodule

// File: rtl/rdma_walker.sv
`timescale 1ns/1ps
module rdma_walker
    import ring_dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  stop_req_i,
    input  word_t ptr_i,
    input  logic  demand_i,
    input  word_t fifo_data_i,
    output logic  fifo_pop_o,
    output word_t fifo_addr_o,
    output logic  mem_req_o,
    output logic  mem_we_o,
    output word_t mem_addr_o,
    output word_t mem_wdata_o,
    input  logic  mem_ready_i,
    input  word_t mem_rdata_i,
    output word_t host_addr_o,
    output logic  tc_irq_o,
    output logic  halt_o
);
    walk_t             st;
    logic [DIDX_W-1:0] widx;
    word_t             base, host_q;
    logic [CNT_W-1:0]  left_q;
    shadow_t           sh;
    logic              hold_q, abort_q;
    logic              acc, last_beat;

    always_comb begin
        halt_o      = (abort_q || stop_req_i) && !hold_q && (st != WK_IDLE);
        mem_we_o    = (st == WK_MOVE);
        mem_req_o   = !halt_o && ((st == WK_FETCH) ||
                                  ((st == WK_MOVE) && (demand_i || hold_q)));
        mem_addr_o  = (st == WK_MOVE) ? host_q
                                      : base + word_t'({widx, {BYTE_SH{1'b0}}});
        mem_wdata_o = fifo_data_i;
        acc         = mem_req_o && mem_ready_i;
        fifo_pop_o  = acc && mem_we_o;
        last_beat   = (left_q == CNT_W'(1));
        tc_irq_o    = fifo_pop_o && last_beat && sh.link[LNK_TCIRQ];
    end

    assign host_addr_o = host_q;
    assign fifo_addr_o = sh.fifo_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= WK_IDLE;
            widx    <= '0;
            base    <= '0;
            host_q  <= '0;
            left_q  <= '0;
            sh      <= '0;
            hold_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            hold_q <= mem_req_o && !mem_ready_i;
            if (halt_o) begin
                st      <= WK_IDLE;
                abort_q <= 1'b0;
            end else begin
                if (stop_req_i && st != WK_IDLE)
                    abort_q <= 1'b1;
                case (st)
                    WK_IDLE: if (start_i) begin
                        st   <= WK_FETCH;
                        base <= desc_base(ptr_i);
                        widx <= '0;
                    end
                    WK_FETCH: if (acc) begin
                        widx <= widx + 1'b1;
                        case (dword_t'(widx))
                            DW_HOST:  host_q       <= mem_rdata_i;
                            DW_LOCAL: sh.fifo_addr <= mem_rdata_i;
                            DW_SIZE:  left_q       <= mem_rdata_i[WORD_W-1:BYTE_SH];
                            default: begin
                                sh.link <= mem_rdata_i;
                                if (left_q == '0)
                                    base <= desc_base(mem_rdata_i);
                                else
                                    st <= WK_MOVE;
                            end
                        endcase
                    end
                    WK_MOVE: if (acc) begin
                        host_q <= beat_step(host_q);
                        left_q <= left_q - 1'b1;
                        if (last_beat) begin
                            st   <= WK_FETCH;
                            base <= desc_base(sh.link);
                            widx <= '0;
                        end
                    end
                    default: st <= WK_IDLE;
                endcase
            end
        end
    end

    AST_HELD_REQ: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> (mem_req_o && mem_addr_o == $past(mem_addr_o)
                    && mem_we_o == $past(mem_we_o))); // R11

    AST_BEAT_ON_DEMAND: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o && !$past(mem_req_o && !mem_ready_i)) |-> demand_i); // R3

    AST_FIFO_ADDR_FIXED: assert property (@(posedge clk) disable iff (rst)
        (st == WK_MOVE && $past(st == WK_MOVE)) |-> $stable(fifo_addr_o)); // R4

    AST_HOST_STEP: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop_o && !last_beat) |=> host_addr_o == beat_step($past(host_addr_o))); // R5

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> !mem_req_o); // R10
endmodule

// File: rtl/ring_dma_engine.sv
`timescale 1ns/1ps
module ring_dma_engine
    import ring_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ptr_we,
    input  logic [WORD_W-1:0] ptr_wdata,
    input  logic            cs_we,
    input  logic [CS_W-1:0] cs_wdata,
    output logic [CS_W-1:0] cs_rdata,
    input  logic            abort,
    input  logic            demand,
    input  logic [WORD_W-1:0] fifo_data,
    output logic            fifo_pop,
    output logic [WORD_W-1:0] fifo_addr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic            mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] host_addr,
    output logic            irq
);
    word_t ptr;
    logic  start, stop_req, tc_irq, halt;

    rdma_csr u_csr (
        .clk        (clk),
        .rst        (rst),
        .ptr_we     (ptr_we),
        .ptr_wdata  (ptr_wdata),
        .cs_we      (cs_we),
        .cs_wdata   (cs_wdata),
        .abort      (abort),
        .tc_irq_i   (tc_irq),
        .halt_i     (halt),
        .ptr_o      (ptr),
        .start_o    (start),
        .stop_req_o (stop_req),
        .cs_rdata   (cs_rdata),
        .irq_o      (irq)
    );

    rdma_walker u_walk (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .stop_req_i  (stop_req),
        .ptr_i       (ptr),
        .demand_i    (demand),
        .fifo_data_i (fifo_data),
        .fifo_pop_o  (fifo_pop),
        .fifo_addr_o (fifo_addr),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_ready_i (mem_ready),
        .mem_rdata_i (mem_rdata),
        .host_addr_o (host_addr),
        .tc_irq_o    (tc_irq),
        .halt_o      (halt)
    );
endmodule

// File: tb/ring_dma_engine_test.sv
`timescale 1ns/1ps
module ring_dma_engine_test;
    import ring_dma_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic        ptr_we = 1'b0, cs_we = 1'b0, abort = 1'b0, demand = 1'b0;
    word_t       ptr_wdata = '0;
    logic [7:0]  cs_wdata = '0;
    logic [7:0]  cs_rdata;
    word_t       fifo_data, fifo_addr, mem_addr, mem_wdata, mem_rdata, host_addr;
    logic        fifo_pop, mem_req, mem_we, mem_ready, irq;

    logic  pat_rdy = 1'b1, force_on = 1'b0, rel = 1'b0;
    word_t dmem [64];
    int    pops = 0, cyc = 0;
    int    n_chk = 0, n_fail = 0;
    int    beats = 0, reads = 0, seg = 0, k = 0;
    word_t rd_base = '0;
    bit    pop_pend = 1'b0, prev_hold = 1'b0;
    word_t prev_addr = '0;
    logic  acc_m;
    word_t exp_a;
    word_t seg_base [2];
    int    seg_len  [2];

    assign fifo_data = 32'hA500_0000 + word_t'(pops);
    assign mem_rdata = (mem_addr < 32'd256) ? dmem[mem_addr[7:2]] : '0;
    assign mem_ready = force_on ? (mem_we ? rel : 1'b1) : pat_rdy;

    ring_dma_engine uut (
        .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .cs_we(cs_we), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata), .abort(abort),
        .demand(demand), .fifo_data(fifo_data), .fifo_pop(fifo_pop), .fifo_addr(fifo_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .host_addr(host_addr), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input word_t act, input word_t exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic cs_write(input logic [7:0] v);
        @(posedge clk); #1;
        cs_we = 1'b1; cs_wdata = v;
        @(posedge clk); #1;
        cs_we = 1'b0; cs_wdata = '0;
    endtask

    task automatic ptr_write(input word_t v);
        @(posedge clk); #1;
        ptr_we = 1'b1; ptr_wdata = v;
        @(posedge clk); #1;
        ptr_we = 1'b0;
    endtask

    task automatic wait_beats(input int n);
        while (beats < n) @(negedge clk);
    endtask

    // stimulus pacing: memory ready, FIFO demand, FIFO advance
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            if (pop_pend) begin pops++; pop_pend = 1'b0; end
            pat_rdy = (cyc % 3) != 1;
            demand  = force_on ? 1'b1 : ((cyc % 5) != 2);
        end
    end

    // observer: every accepted beat against the arithmetic expectation
    always @(negedge clk) begin
        if (!rst) begin
            acc_m = mem_req && mem_ready;
            chk(fifo_pop == (acc_m && mem_we), "R3 pop", word_t'(fifo_pop), word_t'(acc_m && mem_we));
            if (mem_req && mem_we && !prev_hold)
                chk(demand == 1'b1, "R3 demand", word_t'(demand), 32'd1);
            if (prev_hold)
                chk(mem_req && mem_addr == prev_addr, "R11 held", mem_addr, prev_addr);
            if (acc_m && !mem_we) begin
                if (reads < 4)
                    chk(mem_addr == rd_base + word_t'(4 * reads), "R2 fetch", mem_addr,
                        rd_base + word_t'(4 * reads));
                reads++;
            end
            if (acc_m && mem_we) begin
                exp_a = seg_base[seg] + word_t'(4 * k);
                chk(mem_addr == exp_a, "R4 R6 R9 addr", mem_addr, exp_a);
                chk(mem_wdata == 32'hA500_0000 + word_t'(beats), "R4 data", mem_wdata,
                    32'hA500_0000 + word_t'(beats));
                chk(host_addr == mem_addr, "R5 host", host_addr, mem_addr);
                chk(fifo_addr == 32'hF0, "R4 local", fifo_addr, 32'hF0);
                beats++;
                k++;
                if (k == seg_len[seg]) begin seg = 1 - seg; k = 0; end
                pop_pend = 1'b1;
            end
            prev_hold = mem_req && !mem_ready;
            prev_addr = mem_addr;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", word_t'(beats), 32'd0);
        summary();
    end

    initial begin
        int b0;
        seg_base[0] = 32'h1000; seg_len[0] = 3;
        seg_base[1] = 32'h3000; seg_len[1] = 2;
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        dmem[16] = 32'h1000; dmem[17] = 32'hF0; dmem[18] = 32'd12; dmem[19] = 32'h57;
        dmem[20] = 32'h2000; dmem[21] = 32'hF0; dmem[22] = 32'd0;  dmem[23] = 32'h63;
        dmem[24] = 32'h3000; dmem[25] = 32'hF0; dmem[26] = 32'd9;  dmem[27] = 32'h45;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cs_rdata == 8'h00, "R1 status", word_t'(cs_rdata), 32'd0);
        chk(!irq && !mem_req, "R1 quiet", word_t'({irq, mem_req}), 32'd0);
        chk(host_addr == '0, "R1 host", host_addr, 32'd0);
        @(posedge clk); #1 rst = 1'b0;

        rd_base = 32'h40; reads = 0;
        ptr_write(32'h43);
        cs_write(8'h03);
        @(negedge clk);
        chk(cs_rdata[CS_EN] == 1'b1, "R2 enable", word_t'(cs_rdata), 32'h1);

        wait_beats(3);
        @(posedge clk); @(negedge clk);
        chk(irq == 1'b1, "R7 pending", word_t'(irq), 32'd1);
        chk(cs_rdata[CS_PEND] == 1'b1, "R7 status", word_t'(cs_rdata), 32'h21);
        cs_write(8'h09);
        @(negedge clk);
        chk(irq == 1'b0, "R8 cleared", word_t'(irq), 32'd0);
        chk(cs_rdata[CS_EN] == 1'b1, "R8 enable kept", word_t'(cs_rdata), 32'h1);

        wait_beats(5);
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R9 R7 no flag", word_t'(irq), 32'd0);

        wait_beats(8);
        @(posedge clk); @(negedge clk);
        chk(irq == 1'b1, "R6 wrap irq", word_t'(irq), 32'd1);
        cs_write(8'h09);
        wait_beats(20);

        // abort against a stalled write beat
        @(posedge clk); #1 force_on = 1'b1; rel = 1'b0;
        do @(negedge clk); while (!(mem_req && mem_we));
        b0 = beats;
        @(posedge clk); #1 abort = 1'b1;
        @(posedge clk); #1 abort = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b1, "R10 beat held", word_t'(mem_req), 32'd1);
        chk(cs_rdata[CS_EN] == 1'b1, "R10 still on", word_t'(cs_rdata), 32'h1);
        @(posedge clk); #1 rel = 1'b1;
        repeat (4) @(negedge clk);
        chk(beats == b0 + 1, "R10 one beat", word_t'(beats), word_t'(b0 + 1));
        chk(cs_rdata[CS_EN] == 1'b0 && cs_rdata[CS_DONE] == 1'b1, "R10 parked",
            word_t'(cs_rdata), 32'h10);
        @(posedge clk); #1 force_on = 1'b0;
        repeat (10) @(negedge clk);
        chk(!mem_req && beats == b0 + 1, "R10 quiet", word_t'(beats), word_t'(b0 + 1));

        // restart at the third descriptor
        seg = 1; k = 0; reads = 0; rd_base = 32'h60;
        ptr_write(32'h61);
        cs_write(8'h03);
        @(negedge clk);
        chk(cs_rdata[CS_DONE] == 1'b0 && cs_rdata[CS_EN] == 1'b1, "R2 restart",
            word_t'(cs_rdata), 32'h1);
        wait_beats(b0 + 6);
        chk(reads >= 4, "R2 fetched", word_t'(reads), 32'd4);
        summary();
    end
endmodule